// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A compact performance monitoring block with one free-running cycle counter and a parameterised set of event counters (four by default), all 32 bits wide. Software reaches every piece of state through a plain single-cycle register bus. A write is taken on the rising clock edge when `bus_we` is high. A read is combinational: `bus_rdata` always shows the register selected by `bus_addr`. The bus has no stall and no back-pressure, so every access completes in the cycle it is presented.

A global enable in the control register gates every counter at once. Each counter also has its own enable, stored in a word that is set and cleared one bit at a time. While the global enable is low, the stored enables keep their values but have no effect. When a counter wraps from all ones to zero, it latches a sticky overflow flag. Software clears a flag by writing a one to its bit. Bit 31 of the enable and flag words belongs to the cycle counter. Bits 3..0 belong to event counters 3..0.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, the control word, the enables, the overflow flags and every counter read as zero.
- R2: Control bit 0 is the global enable and reads back as written; the other control bits read 0. While it is 0, no counter advances, including the cycle counter.
- R3: The stored enables keep their value while the global enable is 0 and take effect again, unchanged, once it returns to 1.
- R4: Writing to the set word sets each enable whose data bit is 1, and writing to the clear word clears each enable whose data bit is 1; data bits at 0 change nothing. Both words read back the current enables, with bit 31 for the cycle counter, bit i for event counter i, and all other bits 0.
- R5: Event counter i adds exactly one on each clock edge where its event input is high, its enable is 1 and the global enable is 1; otherwise it holds.
- R6: The cycle counter adds one on every clock edge where both its enable (bit 31) and the global enable are 1.
- R7: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag (bit 31 for the cycle counter, bit i for event counter i). Flags stay set until cleared, and reserved flag bits read 0.
- R8: Writing the flag word clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R9: If a counter wraps on the same edge that a write clears its flag, the flag ends up set.
- R10: A write to a counter's value address loads the written value on that edge and leaves its flag unchanged. A load takes priority over an increment on the same edge.
- R11: Address map (4-bit): 0 control, 1 enable set, 2 enable clear, 3 overflow flags, 4 cycle counter, 5 to 8 event counters 0 to 3. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_pulse | input | 4 | One event input per event counter, counted while high |

## Verification
The hardest state to reach is a counter wrapping on the same edge that software clears its flag. The wrap takes four billion events unless the counter is first loaded near its top. The bench therefore loads 0xFFFFFFFF into a counter, then on the next cycle raises that counter's event and writes a one to its flag bit in the same cycle, and reads the flag back. The random phase biases write data toward 0xFFFFFFFF and 0xFFFFFFFE, so wraps, clears and loads keep colliding while every read is compared against a cycle-accurate model in the bench.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CYC_BIT  = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_ENSET = 4'd1,
    A_ENCLR = 4'd2,
    A_FLAG  = 4'd3,
    A_CYC   = 4'd4,
    A_EVT0  = 4'd5
  } pmu_addr_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         wrap
);
  // load has priority; a wrap is only reported for a real step past all ones
  assign wrap = inc & ~load & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + W'(1);
  end

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (value == $past(value) + W'(1)));
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(value));
  a_r10_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value == $past(load_val)));
endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EVT:0]  wrap,     // index NUM_EVT is the cycle counter
  output logic              glb_en,
  output logic [NUM_EVT:0]  run_en,
  output logic [DATA_W-1:0] en_word,
  output logic [DATA_W-1:0] flag_word
);
  localparam int NCNT = NUM_EVT + 1;

  logic [NCNT-1:0] en_q, flag_q, wmask, set_m, clr_m, fclr_m;

  // map bus word onto counter slots: event i -> bit i, cycle -> top bit
  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_map
      assign wmask[i] = wdata[i];
    end
  endgenerate
  assign wmask[NUM_EVT] = wdata[CYC_BIT];

  assign set_m  = (we && addr == A_ENSET) ? wmask : '0;
  assign clr_m  = (we && addr == A_ENCLR) ? wmask : '0;
  assign fclr_m = (we && addr == A_FLAG)  ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (we && addr == A_CTRL) glb_en <= wdata[0];
      en_q   <= (en_q | set_m) & ~clr_m;
      flag_q <= (flag_q & ~fclr_m) | wrap;   // a fresh wrap beats a clear
    end
  end

  assign run_en = glb_en ? en_q : '0;

  always_comb begin
    en_word   = '0;
    flag_word = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      en_word[i]   = en_q[i];
      flag_word[i] = flag_q[i];
    end
    en_word[CYC_BIT]   = en_q[NUM_EVT];
    flag_word[CYC_BIT] = flag_q[NUM_EVT];
  end

  a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((flag_q & $past(wrap)) == $past(wrap)));
  a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fclr_m) && wrap == '0) |=> ((flag_q & $past(fclr_m)) == '0));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_m == '0 && wrap == '0) |=> $stable(flag_q));
  a_r3_enables_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(en_q));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse
);
  localparam int NCNT = NUM_EVT + 1;

  logic              glb_en;
  logic [NCNT-1:0]   run_en, wrap;
  logic [DATA_W-1:0] en_word, flag_word;
  logic [DATA_W-1:0] cnt_val [NCNT];

  pmu_ctrl_regs #(.NUM_EVT(NUM_EVT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .wrap(wrap), .glb_en(glb_en), .run_en(run_en),
    .en_word(en_word), .flag_word(flag_word)
  );

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      localparam logic [ADDR_W-1:0] MY_ADDR =
        (i == NUM_EVT) ? A_CYC : ADDR_W'(int'(A_EVT0) + i);
      logic step;
      if (i == NUM_EVT) begin : g_cyc
        assign step = run_en[i];
      end else begin : g_evt
        assign step = run_en[i] & evt_pulse[i];
      end
      pmu_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(step),
        .load(bus_we && bus_addr == MY_ADDR), .load_val(bus_wdata),
        .value(cnt_val[i]), .wrap(wrap[i])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:          bus_rdata = {{(DATA_W-1){1'b0}}, glb_en};
      A_ENSET, A_ENCLR: bus_rdata = en_word;
      A_FLAG:          bus_rdata = flag_word;
      A_CYC:           bus_rdata = cnt_val[NUM_EVT];
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (bus_addr == ADDR_W'(int'(A_EVT0) + i)) bus_rdata = cnt_val[i];
      end
    endcase
  end

  a_r2_global_off_freezes_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !bus_we) |=> $stable(cnt_val[NUM_EVT]));
  a_r6_cycle_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && en_word[CYC_BIT] && !bus_we) |=>
      (cnt_val[NUM_EVT] == $past(cnt_val[NUM_EVT]) + DATA_W'(1)));
endmodule

// File: tb/test_pmu_counter_unit.sv
`timescale 1ns/1ps
module test_pmu_counter_unit;
  localparam int NE = 4;
  localparam int NC = NE + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NE-1:0] evt_pulse = '0;

  int vectors = 0;
  int fails = 0;

  logic [31:0] m_cnt [NC];
  logic        m_en  [NC];
  logic        m_flag[NC];
  logic        m_glb;

  always #4 clk = ~clk;

  pmu_counter_unit i_pmu_counter_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse)
  );

  function automatic logic [31:0] slot_word(input bit use_flags);
    logic [31:0] w = '0;
    for (int k = 0; k < NE; k++) w[k] = use_flags ? m_flag[k] : m_en[k];
    w[31] = use_flags ? m_flag[NE] : m_en[NE];
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {31'b0, m_glb};
      4'd1, 4'd2: return slot_word(0);
      4'd3: return slot_word(1);
      4'd4: return m_cnt[NE];
      4'd5, 4'd6, 4'd7, 4'd8: return m_cnt[a - 4'd5];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2: return "R4";
      4'd3: return "R7";
      4'd4: return "R6";
      4'd5, 4'd6, 4'd7, 4'd8: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [3:0] addr_of(input int k);
    return (k == NE) ? 4'd4 : 4'(5 + k);
  endfunction

  task automatic model_edge(input logic we, input logic [3:0] a,
                            input logic [31:0] d, input logic [NE-1:0] ev);
    logic wr[NC];
    for (int k = 0; k < NC; k++) begin
      logic inc;
      inc = m_glb && m_en[k] && ((k == NE) ? 1'b1 : ev[k]);
      wr[k] = 1'b0;
      if (we && a == addr_of(k)) m_cnt[k] = d;
      else if (inc) begin
        if (m_cnt[k] == 32'hFFFF_FFFF) wr[k] = 1'b1;
        m_cnt[k] = m_cnt[k] + 32'd1;
      end
    end
    for (int k = 0; k < NC; k++) begin
      logic bit_d;
      bit_d = (k == NE) ? d[31] : d[k];
      if (we && a == 4'd1 && bit_d) m_en[k] = 1'b1;
      if (we && a == 4'd2 && bit_d) m_en[k] = 1'b0;
      if (we && a == 4'd3 && bit_d) m_flag[k] = 1'b0;
      if (wr[k]) m_flag[k] = 1'b1;
    end
    if (we && a == 4'd0) m_glb = d[0];
  endtask

  // drive one cycle, check the read of the current address, advance model
  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic [NE-1:0] ev, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_pulse = ev;
    #1;
    exp = exp_read(a);
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h",
               (tag == "") ? tag_of(a) : tag, a, bus_rdata, exp);
    end
    model_edge(we, a, d, ev);
    @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b0, a, 32'h0, '0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, "");
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      m_cnt[k] = '0; m_en[k] = 1'b0; m_flag[k] = 1'b0;
    end
    m_glb = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state over the whole map
    for (int a = 0; a < 16; a++) rd(4'(a), "R1");

    // R3 / R2: enables stored while globally off, nothing counts
    wr(4'd1, 32'h8000_000F);
    for (int i = 0; i < 5; i++) step(1'b0, 4'd5, 32'h0, 4'hF, "R2");
    rd(4'd4, "R2");
    rd(4'd1, "R3");
    wr(4'd0, 32'hFFFF_FFFF);            // only bit 0 sticks
    rd(4'd0, "R2");
    wr(4'd2, 32'h0000_0004);            // R4 clear enable 2
    rd(4'd2, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, 4'(5 + i), 32'h0, 4'b0101, "R5");
    rd(4'd6, "R5");
    rd(4'd4, "R6");
    rd(4'd1, "R3");

    // R7: event 0 wraps
    wr(4'd5, 32'hFFFF_FFFF);
    step(1'b0, 4'd3, 32'h0, 4'b0001, "R7");
    rd(4'd3, "R7");
    rd(4'd5, "R7");
    // R8: zero write keeps, one write clears
    wr(4'd3, 32'h0000_0000);
    rd(4'd3, "R8");
    wr(4'd3, 32'h0000_0001);
    rd(4'd3, "R8");

    // R9: wrap of event 1 collides with its clear
    wr(4'd1, 32'h0000_0002);
    wr(4'd6, 32'hFFFF_FFFF);
    step(1'b0, 4'd3, 32'h0, 4'b0010, "R9");
    wr(4'd3, 32'h0000_0002);
    step(1'b1, 4'd6, 32'hFFFF_FFFF, 4'b0010, "R9");
    step(1'b1, 4'd3, 32'h0000_0002, 4'b0010, "R9");
    rd(4'd3, "R9");

    // R10: load beats increment, flag untouched
    step(1'b1, 4'd5, 32'h1234_5678, 4'b0001, "R10");
    rd(4'd5, "R10");
    rd(4'd3, "R10");

    // R6 / R7: cycle counter wraps and sets bit 31
    wr(4'd4, 32'hFFFF_FFFE);
    rd(4'd4, "R6");
    rd(4'd3, "R7");

    // R11: unmapped addresses
    for (int a = 9; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    for (int a = 9; a < 16; a++) rd(4'(a), "R11");
    rd(4'd3, "R11");

    // R3: global off then back on
    wr(4'd0, 32'h0);
    rd(4'd1, "R3");
    wr(4'd0, 32'h1);
    rd(4'd1, "R3");

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [3:0] a;
      logic [31:0] d;
      int pick;
      we = ($urandom % 10) < 3;
      a = 4'($urandom % 12);
      pick = $urandom % 4;
      d = (pick == 0) ? 32'hFFFF_FFFF : (pick == 1) ? 32'hFFFF_FFFE : $urandom;
      if (we && a == 4'd0) d[0] = ($urandom % 8) != 0;
      step(we, a, d, 4'($urandom), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule